// File: doc/BRIEF.md
# VPW Bus Symbol Decoder

This block turns the level of a variable-pulse-width serial bus into a stream of decoded symbols. It takes the raw bus level (1 = active, 0 = passive) and a strobe that pulses once per microsecond. After a two-flop synchronizer, it tracks the current level and counts ticks from the most recent transition. A symbol's meaning depends on two things: the polarity of the interval and its measured width.

Symbols come out on a code bus with a one-cycle valid strobe. A data bit also sets a bit-value output. Data bits, start-of-frame and too-short pulses are decided when the interval ends. The long symbols are reported in the cycle the running count reaches their threshold, without waiting for the next transition. These are break while active, and end-of-data, end-of-frame, inter-frame separation and idle while passive. Byte assembly, CRC checking and arbitration belong to downstream logic.

Top module: `vpw_sym_dec`

## Requirements
- R1: While reset is asserted, and afterwards while the bus stays passive with no transition, `sym_valid_o` stays 0 and no symbol is reported.
- R2: An interval of 34 to 96 ticks is reported at its ending transition as code 0 (data bit). An active interval gives `sym_bit_o` = 1 and a passive interval gives `sym_bit_o` = 0. For every code other than 0, `sym_bit_o` is 0.
- R3: An interval of 97 to 163 ticks is reported at its ending transition as code 0 (data bit). An active interval gives `sym_bit_o` = 0 and a passive interval gives `sym_bit_o` = 1.
- R4: An active interval of 164 to 239 ticks is reported at its ending transition as code 1 (start-of-frame).
- R5: An active interval is reported as code 2 (break) when its count reaches 240 ticks. This happens exactly once, while the bus is still active, and the later passive transition adds no symbol.
- R6: A passive interval is reported as code 3 (end-of-data) when its count reaches 164 ticks, as code 4 (end-of-frame) at 280, as code 5 (inter-frame separation) at 300 and as code 6 (idle) at 301. Each is reported once, in that order, and the ending transition adds no symbol.
- R7: An interval of either polarity shorter than 34 ticks is reported at its ending transition as code 7 (invalid).
- R8: Widths are counted in ticks. Clock cycles without `tick_i` do not add to the width.
- R9: If a transition arrives in the same cycle that the count reaches a threshold of R5 or R6, exactly one symbol is reported: the threshold symbol.
- R10: A symbol decided at a transition is valid on the third rising clock edge after `bus_i` changes. A threshold symbol is valid on the third rising edge after the change that started the interval, plus its threshold in ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus level, 1 = active, 0 = passive |
| tick_i | input | 1 | One-cycle strobe, once per microsecond |
| sym_valid_o | output | 1 | One-cycle strobe marking a decoded symbol |
| sym_code_o | output | 3 | Symbol code (0 bit, 1 SOF, 2 break, 3 EOD, 4 EOF, 5 IFS, 6 idle, 7 invalid) |
| sym_bit_o | output | 1 | Value of a data bit; 0 for other codes |

## Verification
A transition can arrive in the same cycle that the running width count crosses a break, end-of-data, end-of-frame or inter-frame threshold. The edge-decided and threshold-decided paths then compete. The bench provokes this by holding the bus for exactly 240 active ticks and exactly 164, 280 and 300 passive ticks, so that the ending edge lands on the threshold tick. It passes only if the received stream has one threshold symbol per interval, with no extra edge symbol and no dropped one.

// File: rtl/vpw_pkg.sv
package vpw_pkg;
  typedef enum logic [2:0] {
    SYM_BIT     = 3'd0,
    SYM_SOF     = 3'd1,
    SYM_BREAK   = 3'd2,
    SYM_EOD     = 3'd3,
    SYM_EOF     = 3'd4,
    SYM_IFS     = 3'd5,
    SYM_IDLE    = 3'd6,
    SYM_INVALID = 3'd7
  } sym_e;
endpackage

// File: rtl/vpw_sync.sv
module vpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q <= '0;
    end else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/vpw_width_cnt.sv
module vpw_width_cnt #(
  parameter int CW  = 9,
  parameter int SAT = 301
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lvl_i,
  input  logic          tick_i,
  output logic          edge_o,
  output logic          pol_o,
  output logic [CW-1:0] width_o,
  output logic          step_o
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  // width seen this cycle includes the current tick; count parks at SAT
  assign step_o  = tick_i && (cnt_q != SAT_V);
  assign width_o = cnt_q + CW'(step_o);
  assign edge_o  = lvl_i ^ lvl_q;
  assign pol_o   = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= SAT_V;
    end else begin
      lvl_q <= lvl_i;
      cnt_q <= edge_o ? '0 : width_o;
    end
  end
endmodule

// File: rtl/vpw_classify.sv
module vpw_classify
  import vpw_pkg::*;
#(
  parameter int CW        = 9,
  parameter int T_MIN     = 34,
  parameter int T_SHORT   = 96,
  parameter int T_LONG    = 163,
  parameter int T_FRAME   = 239,
  parameter int T_EOF     = 280,
  parameter int T_IFS     = 300
) (
  input  logic          edge_i,
  input  logic          pol_i,
  input  logic [CW-1:0] width_i,
  input  logic          step_i,
  output logic          fire_o,
  output sym_e          code_o,
  output logic          bit_o
);
  localparam logic [CW-1:0] MIN_V   = CW'(T_MIN);
  localparam logic [CW-1:0] SHORT_V = CW'(T_SHORT);
  localparam logic [CW-1:0] LONG_V  = CW'(T_LONG);
  localparam logic [CW-1:0] BRK_V   = CW'(T_FRAME + 1);
  localparam logic [CW-1:0] EOD_V   = CW'(T_LONG + 1);
  localparam logic [CW-1:0] EOF_V   = CW'(T_EOF);
  localparam logic [CW-1:0] IFS_V   = CW'(T_IFS);
  localparam logic [CW-1:0] IDLE_V  = CW'(T_IFS + 1);

  logic [CW-1:0] first_th;
  assign first_th = pol_i ? BRK_V : EOD_V;

  always_comb begin
    fire_o = 1'b0;
    code_o = SYM_INVALID;
    bit_o  = 1'b0;
    if (edge_i && (width_i < first_th)) begin
      // interval closed before any threshold symbol was emitted
      fire_o = 1'b1;
      if (width_i < MIN_V) begin
        code_o = SYM_INVALID;
      end else if (width_i <= SHORT_V) begin
        code_o = SYM_BIT;
        bit_o  = pol_i;
      end else if (width_i <= LONG_V) begin
        code_o = SYM_BIT;
        bit_o  = !pol_i;
      end else begin
        code_o = SYM_SOF;
      end
    end else if (step_i) begin
      if (pol_i) begin
        if (width_i == BRK_V) begin
          fire_o = 1'b1;
          code_o = SYM_BREAK;
        end
      end else begin
        if (width_i == EOD_V) begin
          fire_o = 1'b1;
          code_o = SYM_EOD;
        end else if (width_i == EOF_V) begin
          fire_o = 1'b1;
          code_o = SYM_EOF;
        end else if (width_i == IFS_V) begin
          fire_o = 1'b1;
          code_o = SYM_IFS;
        end else if (width_i == IDLE_V) begin
          fire_o = 1'b1;
          code_o = SYM_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/vpw_sym_dec.sv
module vpw_sym_dec
  import vpw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_MIN       = 34,
  parameter int T_SHORT     = 96,
  parameter int T_LONG      = 163,
  parameter int T_FRAME     = 239,
  parameter int T_EOF       = 280,
  parameter int T_IFS       = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_i,
  input  logic       tick_i,
  output logic       sym_valid_o,
  output logic [2:0] sym_code_o,
  output logic       sym_bit_o
);
  localparam int T_IDLE = T_IFS + 1;
  localparam int CW     = $clog2(T_IDLE + 1);

  logic          bus_s;
  logic          edge_w;
  logic          pol_w;
  logic [CW-1:0] width_w;
  logic          step_w;
  logic          fire_w;
  sym_e          code_w;
  logic          bit_w;

  vpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_i),
    .q_o   (bus_s)
  );

  vpw_width_cnt #(.CW(CW), .SAT(T_IDLE)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (bus_s),
    .tick_i (tick_i),
    .edge_o (edge_w),
    .pol_o  (pol_w),
    .width_o(width_w),
    .step_o (step_w)
  );

  vpw_classify #(
    .CW     (CW),
    .T_MIN  (T_MIN),
    .T_SHORT(T_SHORT),
    .T_LONG (T_LONG),
    .T_FRAME(T_FRAME),
    .T_EOF  (T_EOF),
    .T_IFS  (T_IFS)
  ) u_cls (
    .edge_i (edge_w),
    .pol_i  (pol_w),
    .width_i(width_w),
    .step_i (step_w),
    .fire_o (fire_w),
    .code_o (code_w),
    .bit_o  (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_valid_o <= 1'b0;
      sym_code_o  <= 3'd0;
      sym_bit_o   <= 1'b0;
    end else begin
      sym_valid_o <= fire_w;
      sym_code_o  <= fire_w ? code_w : 3'd0;
      sym_bit_o   <= fire_w && bit_w;
    end
  end
endmodule

// File: rtl/vpw_sym_dec_chk.sv
module vpw_sym_dec_chk
  import vpw_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_i,
  input logic       tick_i,
  input logic       sym_valid_o,
  input logic [2:0] sym_code_o,
  input logic       sym_bit_o
);
  logic edge_cls, pas_cls;
  assign edge_cls = (sym_code_o == 3'(SYM_BIT)) || (sym_code_o == 3'(SYM_SOF)) ||
                    (sym_code_o == 3'(SYM_INVALID));
  assign pas_cls  = (sym_code_o == 3'(SYM_EOD)) || (sym_code_o == 3'(SYM_EOF)) ||
                    (sym_code_o == 3'(SYM_IFS)) || (sym_code_o == 3'(SYM_IDLE));

  // R2
  bit_only_on_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && sym_code_o != 3'(SYM_BIT)) |-> !sym_bit_o);

  // R10
  edge_symbol_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && edge_cls) |-> ($past(bus_i, 3) != $past(bus_i, 4)));

  // R5
  break_while_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && sym_code_o == 3'(SYM_BREAK)) |-> $past(bus_i, 4));

  // R6
  passive_symbol_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && pas_cls) |-> !$past(bus_i, 4));

  // R8
  threshold_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_o && (pas_cls || sym_code_o == 3'(SYM_BREAK))) |-> $past(tick_i));
endmodule

bind vpw_sym_dec vpw_sym_dec_chk u_chk (.*);

// File: tb/vpw_sym_dec_tb.sv
module vpw_sym_dec_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] E_B0 = 4'h0, E_B1 = 4'h1, E_SOF = 4'h2, E_BRK = 4'h4,
                         E_EOD = 4'h6, E_EOF = 4'h8, E_IFS = 4'hA, E_IDLE = 4'hC,
                         E_INV = 4'hE;

  logic clk_i = 1'b0, rst_ni = 1'b0, bus_i = 1'b0, tick_i = 1'b0;
  logic sym_valid_o, sym_bit_o;
  logic [2:0] sym_code_o;
  int tick_div = 1;
  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] got_q[$];
  int stamp_q[$];

  vpw_sym_dec u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i)
    if (rst_ni && sym_valid_o) begin
      got_q.push_back({sym_code_o, sym_bit_o});
      stamp_q.push_back(cyc);
    end

  initial begin
    int ph = 0;
    forever @(negedge clk_i) begin
      tick_i = (ph == 0);
      ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic hold(logic lvl, int n);
    bus_i = lvl;
    repeat (n * tick_div) @(negedge clk_i);
  endtask

  task automatic expect_seq(string req, input logic [3:0] exp[$]);
    repeat (8) @(negedge clk_i);
    chk(got_q.size() == exp.size(), req, "symbol count", got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp[i], req, $sformatf("symbol %0d {code,bit}", i), got_q[i], exp[i]);
    got_q.delete();
    stamp_q.delete();
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk_i);
    chk(sym_valid_o == 1'b0, "R1", "valid in reset", sym_valid_o, 0);
    rst_ni = 1'b1;
    repeat (400) @(negedge clk_i);
    chk(got_q.size() == 0, "R1", "symbols after reset", got_q.size(), 0);
    chk(sym_valid_o == 1'b0, "R1", "valid idle", sym_valid_o, 0);
  endtask

  task automatic t_bits();
    int c0 = cyc;
    hold(1, 64); hold(0, 64); hold(1, 128); hold(0, 128);
    hold(1, 34); hold(0, 96); hold(1, 97); hold(0, 163);
    hold(1, 200); hold(0, 400);
    chk(stamp_q.size() > 0 && stamp_q[0] == c0 + 64 + 3, "R10", "edge symbol cycle",
        stamp_q.size() > 0 ? stamp_q[0] : -1, c0 + 67);
    // R2 short, R3 long, R4 SOF at 200, R6 tail
    expect_seq("R2_R3", '{E_B1, E_B0, E_B0, E_B1, E_B1, E_B0, E_B0, E_B1, E_SOF,
                         E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  task automatic t_sof_edges();
    hold(1, 164); hold(0, 64); hold(1, 239); hold(0, 400);
    expect_seq("R4", '{E_SOF, E_B0, E_SOF, E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  task automatic t_break();
    int c0 = cyc;
    hold(1, 300); hold(0, 400);
    chk(stamp_q.size() > 0 && stamp_q[0] == c0 + 240 + 3, "R5", "break cycle",
        stamp_q.size() > 0 ? stamp_q[0] : -1, c0 + 243);
    chk(stamp_q.size() > 4 && stamp_q[4] == c0 + 300 + 301 + 3, "R10", "idle cycle",
        stamp_q.size() > 4 ? stamp_q[4] : -1, c0 + 604);
    expect_seq("R5", '{E_BRK, E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  task automatic t_eod_promo();
    hold(1, 64); hold(0, 250); hold(1, 64); hold(0, 290); hold(1, 64); hold(0, 400);
    expect_seq("R6", '{E_B1, E_EOD, E_B1, E_EOD, E_EOF, E_B1, E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  task automatic t_invalid();
    hold(1, 33); hold(0, 10); hold(1, 64); hold(0, 33); hold(1, 34);
    hold(0, 34); hold(1, 96); hold(0, 400);
    expect_seq("R7", '{E_INV, E_INV, E_B1, E_INV, E_B1, E_B0, E_B1,
                       E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  task automatic t_tick_rate();
    tick_div = 2;
    hold(1, 64); hold(0, 128); hold(1, 128); hold(0, 400);
    expect_seq("R8", '{E_B1, E_B1, E_B0, E_EOD, E_EOF, E_IFS, E_IDLE});
    tick_div = 1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_collide();
    hold(1, 240); hold(0, 164); hold(1, 64); hold(0, 280); hold(1, 64);
    hold(0, 300); hold(1, 64); hold(0, 400);
    expect_seq("R9", '{E_BRK, E_EOD, E_B1, E_EOD, E_EOF, E_B1, E_EOD, E_EOF, E_IFS,
                       E_B1, E_EOD, E_EOF, E_IFS, E_IDLE});
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_bits();
    t_sof_edges();
    t_break();
    t_eod_promo();
    t_invalid();
    t_tick_rate();
    t_collide();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule